// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit side of a descriptor-ring DMA controller. It walks a chain of four-word descriptors in a word-addressed memory. Each descriptor holds a status word (offset 0), a control word (offset 1), a buffer word address (offset 2) and the address of the next descriptor (offset 3). The engine collects the buffer bytes of one or more fragments, from the fragment that carries the start marker to the one that carries the end marker, and hands them to the MAC as a single byte stream. It then writes completion status back into the descriptors, which hands them back to software.

Software loads the current-descriptor pointer, which also turns the transmit process on, and then pulses poll demand. After a clean frame the engine follows the chain to the next descriptor. It goes idle when it meets a descriptor it does not own. A fatal error turns the transmit process off. The engine then ignores poll demands until the pointer is written again.

Top module: `txd_fetch_engine`

## Requirements
- R1: After reset tx_on is 0, cur_ptr is 0, and mem_req, fo_valid, fo_drop and every irq_pulse bit are 0.
- R2: A fetch starts only from idle, with tx_on at 1 and a poll demand pending. A poll while tx_on is 0 is dropped. If the first descriptor has status bit 31 (ownership) at 0, the engine makes that single read, writes nothing, keeps cur_ptr and tx_on, and goes idle.
- R3: Control bits 10:0 give the fragment byte count. Bytes leave in buffer order, and byte 0 of a word is bits 7:0. fo_sop marks only the first byte of the frame and fo_eop marks only its last byte. Data holds steady while fo_ready is low.
- R4: A fragment without the end marker (control bit 22) has its status word written to 0 once its bytes are sent. The engine then fetches the descriptor named by word 3, which must be owned.
- R5: After the last byte, the engine waits for mac_done. It then writes {16'h0, mac_stat & 16'h8F1F} into the end descriptor. This clears bit 31 and keeps retry count 3:0, collision 4, abort 8, late collision 9, carrier lost 10, underflow 11 and excessive collisions 15.
- R6: fo_nocrc follows control bit 16 of the frame's first descriptor for the whole frame.
- R7: A descriptor is invalid in any of four cases: its byte count is 0; it is the first fragment and lacks the start marker (bit 21); it lacks both the end marker and the chain marker (bit 15); or it is a continuation that is not owned. In each case 32'h0000_1000 (bit 12) is written to it. If bytes of the frame were already sent, fo_drop pulses.
- R8: An abort (mac_stat bit 8), an underflow (bit 11) or an invalid descriptor clears tx_on. cur_ptr stays at the descriptor that received the error status, and poll demands are ignored until the pointer is written.
- R9: irq_pulse is a one-cycle vector raised with the final write-back. Bit 1 means a clean frame in which some descriptor had control bit 23 set. Bit 3 means any error (status bits 8, 9, 10, 11, 12 or 15). Bit 9 means underflow and bit 13 means abort.
- R10: A pointer write while idle loads cur_ptr and sets tx_on. It clears any pending poll and does not start a fetch by itself.
- R11: mem_req, mem_we, mem_addr and mem_wdata hold steady from the start of an access until mem_ack. Each access finishes on exactly one mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Strobe: load current-descriptor pointer and turn transmit on |
| ptr_wdata | input | AW | New descriptor word address |
| poll | input | 1 | Poll-demand strobe |
| tx_on | output | 1 | Transmit process enabled |
| cur_ptr | output | AW | Current descriptor word address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| fo_valid | output | 1 | Frame byte valid |
| fo_ready | input | 1 | MAC accepts byte |
| fo_data | output | 8 | Frame byte |
| fo_sop | output | 1 | First byte of frame |
| fo_eop | output | 1 | Last byte of frame |
| fo_nocrc | output | 1 | MAC must not append CRC |
| fo_drop | output | 1 | Discard the partial frame |
| mac_done | input | 1 | MAC finished the frame |
| mac_stat | input | 16 | MAC completion status |
| irq_pulse | output | IRQ_W | Interrupt event pulses |

## Verification
The bench builds the engine with AW=8, so a 256-word model holds every descriptor and buffer and the wrap-free pointer arithmetic is fully exercised. It also sets LITTLE_END=1, which selects the low-byte-first lane order that the expected streams assume, and IRQ_W=16 so that all four event bits are visible. With these values, frames of one to three fragments, odd byte counts that leave partial words, periodic backpressure and every halting and non-halting status pattern all fit in a short run.

// File: rtl/txd_pkg.sv
package txd_pkg;
   localparam int unsigned WORD_W   = 32;
   // control word fields
   localparam int CTL_CNT_HI = 10;
   localparam int CTL_CHAIN  = 15;
   localparam int CTL_NOCRC  = 16;
   localparam int CTL_SOP    = 21;
   localparam int CTL_EOP    = 22;
   localparam int CTL_IRQ    = 23;
   // status word fields
   localparam int ST_OWN     = 31;
   localparam int ST_ABORT   = 8;
   localparam int ST_UNDER   = 11;
   localparam int ST_BADDESC = 12;
   localparam logic [15:0] ST_KEEP  = 16'h8F1F;
   localparam logic [15:0] ST_FAULT = 16'h8F00;
   // interrupt event positions
   localparam int IRQ_DONE  = 1;
   localparam int IRQ_ERR   = 3;
   localparam int IRQ_UNDER = 9;
   localparam int IRQ_ABORT = 13;
   // descriptor word offsets
   localparam int OFS_STAT = 0;
   localparam int OFS_CTL  = 1;
   localparam int OFS_BUF  = 2;
   localparam int OFS_NEXT = 3;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_ST, S_RD_CTL, S_RD_BUF, S_RD_NXT, S_CHECK,
      S_FETCH, S_EMIT, S_WB_MID, S_WAIT_MAC, S_WB_END, S_WB_BAD
   } txd_state_e;
endpackage

// File: rtl/txd_lane_sel.sv
module txd_lane_sel #(
   parameter bit LITTLE_END = 1'b1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  lane_i,
   output logic [7:0]  byte_o
);
   generate
      if (LITTLE_END) begin : g_low_first
         assign byte_o = word_i[{lane_i, 3'b000} +: 8];
      end else begin : g_high_first
         assign byte_o = word_i[{~lane_i, 3'b000} +: 8];
      end
   endgenerate
endmodule

// File: rtl/txd_desc_check.sv
module txd_desc_check #(
   parameter int CNT_W = 11
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             sop_i,
   input  logic             eop_i,
   input  logic             chain_i,
   input  logic             first_i,
   output logic             bad_o
);
   logic empty, no_start, dangling;
   assign empty    = (cnt_i == '0);
   assign no_start = first_i && !sop_i;
   assign dangling = !eop_i && !chain_i;
   assign bad_o    = empty || no_start || dangling;
endmodule

// File: rtl/txd_irq_map.sv
module txd_irq_map #(
   parameter int IRQ_W = 16
) (
   input  logic [15:0]      stat_i,
   input  logic             bad_i,
   input  logic             ic_i,
   output logic [31:0]      wb_o,
   output logic [IRQ_W-1:0] irq_o,
   output logic             halt_o
);
   import txd_pkg::*;
   logic fault;
   assign fault = |(stat_i & ST_FAULT);

   always_comb begin
      irq_o  = '0;
      wb_o   = '0;
      halt_o = 1'b0;
      if (bad_i) begin
         wb_o[ST_BADDESC] = 1'b1;
         irq_o[IRQ_ERR]   = 1'b1;
         halt_o           = 1'b1;
      end else begin
         wb_o             = {16'h0000, stat_i & ST_KEEP};
         irq_o[IRQ_ERR]   = fault;
         irq_o[IRQ_UNDER] = stat_i[ST_UNDER];
         irq_o[IRQ_ABORT] = stat_i[ST_ABORT];
         irq_o[IRQ_DONE]  = !fault && ic_i;
         halt_o           = stat_i[ST_ABORT] || stat_i[ST_UNDER];
      end
   end
endmodule

// File: rtl/txd_fetch_engine.sv
module txd_fetch_engine #(
   parameter int AW         = 16,
   parameter bit LITTLE_END = 1'b1,
   parameter int IRQ_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_wr,
   input  logic [AW-1:0]    ptr_wdata,
   input  logic             poll,
   output logic             tx_on,
   output logic [AW-1:0]    cur_ptr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   input  logic             mem_ack,
   output logic             fo_valid,
   input  logic             fo_ready,
   output logic [7:0]       fo_data,
   output logic             fo_sop,
   output logic             fo_eop,
   output logic             fo_nocrc,
   output logic             fo_drop,
   input  logic             mac_done,
   input  logic [15:0]      mac_stat,
   output logic [IRQ_W-1:0] irq_pulse
);
   import txd_pkg::*;

   localparam int CNT_W = CTL_CNT_HI + 1;
   localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
   localparam logic [AW-1:0] A_CTL  = AW'(OFS_CTL);
   localparam logic [AW-1:0] A_BUF  = AW'(OFS_BUF);
   localparam logic [AW-1:0] A_NEXT = AW'(OFS_NEXT);

   generate
      if (AW < 4 || AW > 32) begin : g_bad_aw
         $error("txd_fetch_engine: AW must lie in 4..32");
      end
      if (IRQ_W < IRQ_ABORT + 1) begin : g_bad_irq
         $error("txd_fetch_engine: IRQ_W too narrow for event bits");
      end
   endgenerate

   txd_state_e       state;
   logic [AW-1:0]    cur_q, nxt_q, buf_q;
   logic [31:0]      word_q;
   logic [CNT_W-1:0] d_cnt, remain_q;
   logic             d_chain, d_sop, d_eop, d_ic, d_nocrc;
   logic [1:0]       lane_q;
   logic             first_q, started_q, ic_q, nocrc_q;
   logic [15:0]      stat_q;
   logic             tx_on_q, poll_q, drop_q;
   logic [IRQ_W-1:0] irq_q;

   logic             bad_desc;
   logic [31:0]      map_wb;
   logic [IRQ_W-1:0] map_irq;
   logic             map_halt;
   logic [7:0]       lane_byte;

   txd_desc_check #(.CNT_W(CNT_W)) u_check (
      .cnt_i(d_cnt), .sop_i(d_sop), .eop_i(d_eop), .chain_i(d_chain),
      .first_i(first_q), .bad_o(bad_desc)
   );

   txd_irq_map #(.IRQ_W(IRQ_W)) u_map (
      .stat_i(stat_q), .bad_i(state == S_WB_BAD), .ic_i(ic_q),
      .wb_o(map_wb), .irq_o(map_irq), .halt_o(map_halt)
   );

   txd_lane_sel #(.LITTLE_END(LITTLE_END)) u_lane (
      .word_i(word_q), .lane_i(lane_q), .byte_o(lane_byte)
   );

   // memory port
   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = '0;
      case (state)
         S_RD_ST:  mem_addr = cur_q + A_STAT;
         S_RD_CTL: mem_addr = cur_q + A_CTL;
         S_RD_BUF: mem_addr = cur_q + A_BUF;
         S_RD_NXT: mem_addr = cur_q + A_NEXT;
         S_FETCH:  mem_addr = buf_q;
         S_WB_MID: mem_we   = 1'b1;
         S_WB_END, S_WB_BAD: begin
            mem_we    = 1'b1;
            mem_wdata = map_wb;
         end
         default:  mem_req  = 1'b0;
      endcase
   end

   // frame stream
   assign fo_valid  = (state == S_EMIT);
   assign fo_data   = lane_byte;
   assign fo_sop    = fo_valid && first_q && !started_q;
   assign fo_eop    = fo_valid && d_eop && (remain_q == CNT_W'(1));
   assign fo_nocrc  = nocrc_q;
   assign fo_drop   = drop_q;
   assign tx_on     = tx_on_q;
   assign cur_ptr   = cur_q;
   assign irq_pulse = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cur_q     <= '0;
         nxt_q     <= '0;
         buf_q     <= '0;
         word_q    <= '0;
         d_cnt     <= '0;
         d_chain   <= 1'b0;
         d_sop     <= 1'b0;
         d_eop     <= 1'b0;
         d_ic      <= 1'b0;
         d_nocrc   <= 1'b0;
         remain_q  <= '0;
         lane_q    <= '0;
         first_q   <= 1'b1;
         started_q <= 1'b0;
         ic_q      <= 1'b0;
         nocrc_q   <= 1'b0;
         stat_q    <= '0;
         tx_on_q   <= 1'b0;
         poll_q    <= 1'b0;
         drop_q    <= 1'b0;
         irq_q     <= '0;
      end else begin
         irq_q  <= '0;
         drop_q <= 1'b0;
         if (poll && tx_on_q) poll_q <= 1'b1;
         case (state)
            S_IDLE: begin
               if (ptr_wr) begin
                  cur_q     <= ptr_wdata;
                  tx_on_q   <= 1'b1;
                  poll_q    <= 1'b0;
                  first_q   <= 1'b1;
                  started_q <= 1'b0;
                  ic_q      <= 1'b0;
               end else if (tx_on_q && (poll_q || poll)) begin
                  poll_q <= 1'b0;
                  state  <= S_RD_ST;
               end
            end
            S_RD_ST: if (mem_ack) begin
               if (!mem_rdata[ST_OWN]) state <= first_q ? S_IDLE : S_WB_BAD;
               else                    state <= S_RD_CTL;
            end
            S_RD_CTL: if (mem_ack) begin
               d_cnt   <= mem_rdata[CTL_CNT_HI:0];
               d_chain <= mem_rdata[CTL_CHAIN];
               d_nocrc <= mem_rdata[CTL_NOCRC];
               d_sop   <= mem_rdata[CTL_SOP];
               d_eop   <= mem_rdata[CTL_EOP];
               d_ic    <= mem_rdata[CTL_IRQ];
               state   <= S_RD_BUF;
            end
            S_RD_BUF: if (mem_ack) begin
               buf_q <= mem_rdata[AW-1:0];
               state <= S_RD_NXT;
            end
            S_RD_NXT: if (mem_ack) begin
               nxt_q <= mem_rdata[AW-1:0];
               state <= S_CHECK;
            end
            S_CHECK: begin
               if (bad_desc) begin
                  state <= S_WB_BAD;
               end else begin
                  remain_q <= d_cnt;
                  lane_q   <= '0;
                  if (first_q) nocrc_q <= d_nocrc;
                  ic_q     <= ic_q || d_ic;
                  state    <= S_FETCH;
               end
            end
            S_FETCH: if (mem_ack) begin
               word_q <= mem_rdata;
               buf_q  <= buf_q + AW'(1);
               state  <= S_EMIT;
            end
            S_EMIT: if (fo_ready) begin
               remain_q  <= remain_q - CNT_W'(1);
               lane_q    <= lane_q + 2'd1;
               started_q <= 1'b1;
               if (remain_q == CNT_W'(1)) state <= d_eop ? S_WAIT_MAC : S_WB_MID;
               else if (lane_q == 2'd3)   state <= S_FETCH;
            end
            S_WB_MID: if (mem_ack) begin
               cur_q   <= nxt_q;
               first_q <= 1'b0;
               state   <= S_RD_ST;
            end
            S_WAIT_MAC: if (mac_done) begin
               stat_q <= mac_stat;
               state  <= S_WB_END;
            end
            S_WB_END: if (mem_ack) begin
               irq_q     <= map_irq;
               first_q   <= 1'b1;
               started_q <= 1'b0;
               ic_q      <= 1'b0;
               if (map_halt) begin
                  tx_on_q <= 1'b0;
                  state   <= S_IDLE;
               end else begin
                  cur_q <= nxt_q;
                  state <= S_RD_ST;
               end
            end
            S_WB_BAD: if (mem_ack) begin
               irq_q     <= map_irq;
               tx_on_q   <= 1'b0;
               drop_q    <= started_q;
               first_q   <= 1'b1;
               started_q <= 1'b0;
               ic_q      <= 1'b0;
               state     <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txd_fetch_engine_chk.sv
module txd_fetch_engine_chk #(
   parameter int AW    = 16,
   parameter int IRQ_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_on,
   input logic             mem_req,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [31:0]      mem_wdata,
   input logic             mem_ack,
   input logic             fo_valid,
   input logic             fo_ready,
   input logic [7:0]       fo_data,
   input logic             fo_sop,
   input logic             fo_eop,
   input logic [IRQ_W-1:0] irq_pulse
);
   // R11: access stays put until acknowledged
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R3: stream byte held under backpressure
   p_stream_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fo_valid && !fo_ready) |=> (fo_valid && $stable(fo_data) && $stable(fo_sop) && $stable(fo_eop)));

   // R2: no new memory traffic while transmit is off
   p_quiet_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_on && !mem_req) |=> !mem_req);

   // R9: cause bits always accompany the error bit
   p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse[9] || irq_pulse[13]) |-> irq_pulse[3]);

   // R9: completion and error never together
   p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse[1] |-> !irq_pulse[3]);

   // R8: abort or underflow has turned transmit off
   p_fatal_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse[9] || irq_pulse[13]) |-> !tx_on);
endmodule

bind txd_fetch_engine txd_fetch_engine_chk #(.AW(AW), .IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/tb_txd_fetch_engine.sv
module tb_txd_fetch_engine;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          ptr_wr = 1'b0, poll = 1'b0, mac_done = 1'b0;
   logic [AW-1:0] ptr_wdata = '0;
   logic [15:0]   mac_stat = '0;
   logic          tx_on, mem_req, mem_we, fo_valid, fo_ready, fo_sop, fo_eop, fo_nocrc, fo_drop;
   logic [AW-1:0] cur_ptr, mem_addr;
   logic [31:0]   mem_wdata;
   logic [31:0]   rdata_r = '0;
   logic          ack_r = 1'b0;
   logic [7:0]    fo_data;
   logic [15:0]   irq_pulse;

   txd_fetch_engine #(.AW(AW), .LITTLE_END(1'b1), .IRQ_W(16)) dut (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .poll(poll),
      .tx_on(tx_on), .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_r), .mem_ack(ack_r),
      .fo_valid(fo_valid), .fo_ready(fo_ready), .fo_data(fo_data), .fo_sop(fo_sop),
      .fo_eop(fo_eop), .fo_nocrc(fo_nocrc), .fo_drop(fo_drop), .mac_done(mac_done),
      .mac_stat(mac_stat), .irq_pulse(irq_pulse)
   );

   // memory model: acknowledge one cycle after request
   logic [31:0] mem [0:255];
   always @(posedge clk) begin
      if (mem_req && !ack_r) begin
         ack_r   <= 1'b1;
         rdata_r <= mem[mem_addr];
         if (mem_we) mem[mem_addr] <= mem_wdata;
      end else begin
         ack_r <= 1'b0;
      end
   end

   // periodic backpressure
   logic [1:0] rc = 2'd0;
   always @(posedge clk) rc <= rc + 2'd1;
   assign fo_ready = (rc != 2'd3);

   // collector
   logic        clr = 1'b0;
   int          rx_n = 0, sop_cnt = 0, eop_cnt = 0, ack_cnt = 0;
   logic [7:0]  rx_data [0:63];
   logic        sop_first = 1'b0, nocrc_seen = 1'b0, drop_seen = 1'b0;
   logic [15:0] irq_acc = '0;
   always @(posedge clk) begin
      if (clr) begin
         rx_n <= 0; sop_cnt <= 0; eop_cnt <= 0; ack_cnt <= 0;
         sop_first <= 1'b0; nocrc_seen <= 1'b0; drop_seen <= 1'b0; irq_acc <= '0;
      end else begin
         if (fo_valid && fo_ready) begin
            if (rx_n < 64) rx_data[rx_n] <= fo_data;
            if (rx_n == 0) begin
               sop_first  <= fo_sop;
               nocrc_seen <= fo_nocrc;
            end
            sop_cnt <= sop_cnt + int'(fo_sop);
            eop_cnt <= eop_cnt + int'(fo_eop);
            rx_n    <= rx_n + 1;
         end
         if (ack_r) ack_cnt <= ack_cnt + 1;
         if (fo_drop) drop_seen <= 1'b1;
         irq_acc <= irq_acc | irq_pulse;
      end
   end

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic clear();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   task automatic load_ptr(input int a);
      @(negedge clk); ptr_wr = 1'b1; ptr_wdata = AW'(a);
      @(negedge clk); ptr_wr = 1'b0;
   endtask

   task automatic do_poll();
      poll = 1'b1;
      @(negedge clk); poll = 1'b0;
   endtask

   task automatic set_desc(input int a, input logic [31:0] st, input logic [31:0] ctl,
                           input int bufa, input int nxt);
      mem[a] = st; mem[a+1] = ctl; mem[a+2] = 32'(bufa); mem[a+3] = 32'(nxt);
   endtask

   function automatic logic [31:0] mk_ctl(input int len, input bit chain, input bit nocrc,
                                          input bit sop, input bit eop, input bit ic);
      logic [31:0] c = 32'(len) & 32'h7FF;
      c[15] = chain; c[16] = nocrc; c[21] = sop; c[22] = eop; c[23] = ic;
      return c;
   endfunction

   // stimulus / expected vectors
   typedef struct packed {
      logic [1:0]  nfrag;
      logic [7:0]  l0, l1, l2;
      logic        ic, nocrc;
      logic [15:0] stat;
      logic [15:0] exp_irq;
      logic        exp_halt;
   } vec_t;
   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 8'd5, 8'd0, 8'd0, 1'b1, 1'b0, 16'h0000, 16'h0002, 1'b0},
      '{2'd2, 8'd3, 8'd6, 8'd0, 1'b0, 1'b0, 16'h0013, 16'h0000, 1'b0},
      '{2'd3, 8'd4, 8'd1, 8'd7, 1'b1, 1'b1, 16'h0400, 16'h0008, 1'b0},
      '{2'd1, 8'd8, 8'd0, 8'd0, 1'b1, 1'b0, 16'h0800, 16'h0208, 1'b1},
      '{2'd2, 8'd2, 8'd2, 8'd0, 1'b1, 1'b1, 16'h0100, 16'h2008, 1'b1},
      '{2'd1, 8'd1, 8'd0, 8'd0, 1'b1, 1'b0, 16'hF0E0, 16'h0008, 1'b0}
   };

   logic [7:0] exp_b [0:63];

   task automatic run_vec(input int i);
      vec_t v = VEC[i];
      int base = i * 16;
      int n = int'(v.nfrag);
      int tot = 0;
      int w = 0;
      int bad_bytes = 0;
      for (int k = 0; k < n; k++) begin
         int len  = (k == 0) ? int'(v.l0) : (k == 1) ? int'(v.l1) : int'(v.l2);
         int bufa = 128 + i * 16 + k * 5;
         set_desc(base + 4 * k, 32'h8000_0000,
                  mk_ctl(len, k < n - 1, (k == 0) && v.nocrc, k == 0, k == n - 1, (k == n - 1) && v.ic),
                  bufa, (k < n - 1) ? base + 4 * (k + 1) : base + 12);
         for (int j = 0; j < len; j++) begin
            logic [7:0] b = 8'(i * 40 + k * 10 + j + 1);
            mem[bufa + j / 4][8 * (j % 4) +: 8] = b;
            exp_b[tot] = b;
            tot++;
         end
      end
      mem[base + 12] = 32'h0;
      clear();
      load_ptr(base);
      do_poll();
      while (eop_cnt == 0 && w < 500) begin
         @(negedge clk); w++;
      end
      repeat (3) @(negedge clk);
      mac_done = 1'b1; mac_stat = v.stat;
      @(negedge clk);
      mac_done = 1'b0; mac_stat = '0;
      repeat (30) @(negedge clk);

      chk(rx_n == tot, $sformatf("R3 vec%0d byte count", i), rx_n, tot);
      for (int j = 0; j < tot && j < 64; j++)
         if (rx_data[j] !== exp_b[j]) bad_bytes++;
      chk(bad_bytes == 0, $sformatf("R3 vec%0d byte content mismatches", i), bad_bytes, 0);
      chk(sop_first && sop_cnt == 1 && eop_cnt == 1, $sformatf("R3 vec%0d sop/eop marks", i),
          {sop_cnt[7:0], eop_cnt[7:0]}, 16'h0101);
      chk(nocrc_seen == v.nocrc, $sformatf("R6 vec%0d nocrc", i), nocrc_seen, v.nocrc);
      for (int k = 0; k < n - 1; k++)
         chk(mem[base + 4 * k] == 32'h0, $sformatf("R4 vec%0d mid status %0d", i, k), mem[base + 4 * k], 0);
      chk(mem[base + 4 * (n - 1)] == {16'h0, v.stat & 16'h8F1F}, $sformatf("R5 vec%0d end status", i),
          mem[base + 4 * (n - 1)], {16'h0, v.stat & 16'h8F1F});
      chk(irq_acc == v.exp_irq, $sformatf("R9 vec%0d irq", i), irq_acc, v.exp_irq);
      chk(tx_on == !v.exp_halt, $sformatf("R8 vec%0d tx_on", i), tx_on, !v.exp_halt);
      chk(cur_ptr == AW'(v.exp_halt ? base + 4 * (n - 1) : base + 12), $sformatf("R4 R8 vec%0d pointer", i),
          cur_ptr, v.exp_halt ? base + 4 * (n - 1) : base + 12);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = 32'h0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_on == 1'b0, "R1 tx_on", tx_on, 0);
      chk(cur_ptr == '0, "R1 cur_ptr", cur_ptr, 0);
      chk(!mem_req && !fo_valid && !fo_drop && irq_pulse == '0, "R1 outputs idle",
          {mem_req, fo_valid, fo_drop, irq_pulse}, 0);
      rst_n = 1'b1;
      clear();

      // R2: poll while off is dropped
      set_desc(0, 32'h8000_0000, mk_ctl(4, 0, 0, 1, 1, 1), 200, 12);
      do_poll();
      repeat (10) @(negedge clk);
      chk(ack_cnt == 0, "R2 poll while off", ack_cnt, 0);

      // R10: pointer write loads, no fetch without poll
      clear();
      load_ptr(8'h60);
      chk(cur_ptr == 8'h60 && tx_on == 1'b1, "R10 pointer load", {tx_on, cur_ptr}, 9'h160);
      repeat (10) @(negedge clk);
      chk(ack_cnt == 0, "R10 no fetch without poll", ack_cnt, 0);

      // R2/R11: unowned first descriptor
      mem[8'h60] = 32'h0; mem[8'h61] = mk_ctl(4, 0, 0, 1, 1, 1);
      do_poll();
      repeat (20) @(negedge clk);
      chk(ack_cnt == 1, "R2 R11 single read on unowned", ack_cnt, 1);
      chk(mem[8'h60] == 32'h0 && tx_on && cur_ptr == 8'h60, "R2 unowned idle",
          {tx_on, cur_ptr}, 9'h160);

      // vector table
      for (int i = 0; i < NV; i++) run_vec(i);

      // R7: zero byte count
      clear();
      set_desc(8'h64, 32'h8000_0000, mk_ctl(0, 0, 0, 1, 1, 1), 8'hF0, 8'h60);
      load_ptr(8'h64); do_poll();
      repeat (20) @(negedge clk);
      chk(mem[8'h64] == 32'h0000_1000, "R7 zero count status", mem[8'h64], 32'h1000);
      chk(irq_acc == 16'h0008 && rx_n == 0 && !drop_seen, "R7 R9 zero count irq", irq_acc, 16'h0008);
      chk(!tx_on && cur_ptr == 8'h64, "R8 halt on invalid", {tx_on, cur_ptr}, 9'h064);

      // R8: poll while halted ignored
      clear();
      mem[8'h64] = 32'h8000_0000;
      do_poll();
      repeat (15) @(negedge clk);
      chk(ack_cnt == 0 && mem[8'h64] == 32'h8000_0000, "R8 poll ignored when halted", ack_cnt, 0);

      // R7: missing start marker
      clear();
      set_desc(8'h68, 32'h8000_0000, mk_ctl(4, 0, 0, 0, 1, 0), 8'hF0, 8'h60);
      load_ptr(8'h68); do_poll();
      repeat (20) @(negedge clk);
      chk(mem[8'h68] == 32'h0000_1000 && !tx_on, "R7 missing start", mem[8'h68], 32'h1000);

      // R7: no end and no chain
      clear();
      set_desc(8'h78, 32'h8000_0000, mk_ctl(2, 0, 0, 1, 0, 0), 8'hF0, 8'h60);
      load_ptr(8'h78); do_poll();
      repeat (20) @(negedge clk);
      chk(mem[8'h78] == 32'h0000_1000 && rx_n == 0, "R7 dangling fragment", mem[8'h78], 32'h1000);

      // R7: continuation not owned -> drop partial frame
      clear();
      mem[8'hF0] = 32'h0403_0201;
      set_desc(8'h70, 32'h8000_0000, mk_ctl(3, 1, 0, 1, 0, 0), 8'hF0, 8'h74);
      mem[8'h74] = 32'h0;
      load_ptr(8'h70); do_poll();
      repeat (40) @(negedge clk);
      chk(rx_n == 3, "R7 partial bytes", rx_n, 3);
      chk(drop_seen, "R7 drop pulse", drop_seen, 1);
      chk(mem[8'h70] == 32'h0 && mem[8'h74] == 32'h0000_1000, "R4 R7 statuses", mem[8'h74], 32'h1000);
      chk(!tx_on && cur_ptr == 8'h74 && irq_acc == 16'h0008, "R8 R9 unowned continuation",
          {tx_on, cur_ptr}, 9'h074);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule